// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Detection

This block is the receive side of a synchronous serial channel that runs in continuous transfer mode. A serial clock and a serial data line come in from outside the system clock domain. Both are passed through a synchronizer. While reception is enabled, each rising edge of the synchronized serial clock samples one data bit into a shift register, most significant bit first. After eight samples the finished word is copied into a receive data register, and a one-cycle completion pulse is raised.

The block watches whether software reads each word in time. A read counts only if it arrives no later than the falling serial clock edge that comes just before the last bit of the next word is sampled. If that point passes while the word is still unread, the next word end does three things: it sets a sticky overrun flag, raises a one-cycle error pulse, and overwrites the receive register regardless. The error pulse comes back at every later word end for as long as no read arrives in time. The overrun flag is cleared only by a clear strobe or by reset.

Top module: `csrx_receiver`

## Requirements
- R1: While `rst` is high at a clock edge, `rx_data` becomes 0, and `ovf_flag`, `rx_done` and `rx_err` become 0.
- R2: While `rx_en` is 1, each rising edge of the synchronized `sclk_in` samples `sdata_in`. The first sample lands in bit 7 of the word and the eighth in bit 0 (MSB first). For example, the bit sequence 1,0,1,0,1,0,1,0 yields 8'hAA.
- R3: When the eighth sample of a word is taken, `rx_data` takes the new word and `rx_done` is high for exactly one clock, in the same cycle. `rx_data` changes in no other cycle.
- R4: A word that is read with `rd_stb` before or at the falling serial clock edge that precedes the last sample of the next word causes no `rx_err` and no overrun at the end of that next word.
- R5: If the word is still unread at that falling edge, the end of the next word sets `ovf_flag` to 1 and raises `rx_err` for one clock, together with `rx_done`. `rx_data` is still overwritten with the new word.
- R6: While no read arrives in time, `rx_err` is raised again at every following word end.
- R7: A `rd_stb` that comes after the falling edge of the deadline, but before the word ends, does not prevent the `rx_err` and overrun at that word end.
- R8: `ovf_flag` stays 1 through reads and later words. It returns to 0 only after an `ovf_clr` pulse or reset.
- R9: While `rx_en` is 0, serial clock edges sample nothing, and neither `rx_done` nor `rx_data` changes. The bit counter is cleared, so after re-enabling, the next word starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Reception enable |
| sclk_in | input | 1 | Serial clock, asynchronous to `clk`, idles low |
| sdata_in | input | 1 | Serial data, asynchronous to `clk` |
| rd_stb | input | 1 | One-cycle strobe: software has read `rx_data` |
| ovf_clr | input | 1 | One-cycle strobe that clears `ovf_flag` |
| rx_data | output | 8 | Last completed received word |
| rx_done | output | 1 | One-cycle pulse at each word end |
| rx_err | output | 1 | One-cycle pulse at a word end that overran an unread word |
| ovf_flag | output | 1 | Sticky overrun flag |

## Verification
The embedded assertions check, on every cycle, the following:
- the completion pulse lasts one cycle;
- the receive register changes only alongside that pulse;
- every error pulse coincides with a completion pulse and a set overrun flag;
- the flag is sticky until cleared;
- disabling reception holds the bit counter at zero.

Only the directed scenarios can show the rest:
- the MSB-first word values;
- where the read deadline falls, by issuing reads just before and just after the deadline edge;
- that errors repeat while no read arrives;
- that a partial word is discarded when reception is disabled.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  localparam int CSRX_WORD_W    = 8;
  localparam int CSRX_SYNC_DEPTH = 2;
endpackage

// File: rtl/csrx_sync.sv
module csrx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], async_in[g]};
    end
    assign sync_out[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/csrx_edge.sv
module csrx_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end
  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/csrx_shifter.sv
module csrx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sample,
  input  logic              fall,
  input  logic              din,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic              deadline
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      bit_cnt <= '0;
      if (rst) shreg <= '0;
    end else if (sample) begin
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CNT_W'(1);
      shreg   <= {shreg[WORD_W-2:0], din};
    end
  end

  assign word      = {shreg[WORD_W-2:0], din};
  assign word_done = enable & sample & (bit_cnt == LAST);
  assign deadline  = enable & fall & (bit_cnt == LAST);

  // R9: disabling reception clears the counter
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> bit_cnt == '0);
endmodule

// File: rtl/csrx_ovr_track.sv
module csrx_ovr_track #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic              deadline,
  input  logic              rd_stb,
  input  logic              ovf_clr,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_err,
  output logic              ovf_flag
);
  logic unread;
  logic missed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_done  <= 1'b0;
      rx_err   <= 1'b0;
      ovf_flag <= 1'b0;
      unread   <= 1'b0;
      missed   <= 1'b0;
    end else begin
      rx_done <= word_done;
      rx_err  <= word_done & missed;
      if (word_done) begin
        rx_data <= word;
        unread  <= 1'b1;
        missed  <= 1'b0;
      end else begin
        if (rd_stb) unread <= 1'b0;
        if (deadline && unread && !rd_stb) missed <= 1'b1;
      end
      if (word_done && missed) ovf_flag <= 1'b1;
      else if (ovf_clr)        ovf_flag <= 1'b0;
    end
  end

  // R3: completion pulse lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  // R3: receive register only changes with a completion
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rx_done |-> $stable(rx_data));
  // R5: error pulse only at a word end, with the flag set
  p_err_at_done_r5: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> (rx_done && ovf_flag));
  // R8: flag is sticky until cleared
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/csrx_receiver.sv
module csrx_receiver
  import csrx_pkg::*;
#(
  parameter int WORD_W     = CSRX_WORD_W,
  parameter int SYNC_DEPTH = CSRX_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              rd_stb,
  input  logic              ovf_clr,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_err,
  output logic              ovf_flag
);
  logic [1:0]        synced;
  logic              s_rise, s_fall;
  logic              word_done, deadline;
  logic [WORD_W-1:0] word;

  csrx_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({sdata_in, sclk_in}),
    .sync_out(synced)
  );

  csrx_edge u_edge (
    .clk(clk), .rst(rst), .level(synced[0]),
    .rise(s_rise), .fall(s_fall)
  );

  csrx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .enable(rx_en),
    .sample(s_rise), .fall(s_fall), .din(synced[1]),
    .word_done(word_done), .word(word), .deadline(deadline)
  );

  csrx_ovr_track #(.WORD_W(WORD_W)) u_track (
    .clk(clk), .rst(rst),
    .word_done(word_done), .word(word), .deadline(deadline),
    .rd_stb(rd_stb), .ovf_clr(ovf_clr),
    .rx_data(rx_data), .rx_done(rx_done), .rx_err(rx_err),
    .ovf_flag(ovf_flag)
  );
endmodule

// File: tb/csrx_receiver_tb.sv
`timescale 1ns/100ps
module csrx_receiver_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, sclk_in = 1'b0, sdata_in = 1'b0;
  logic rd_stb = 1'b0, ovf_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_done, rx_err, ovf_flag;

  int checks = 0, failures = 0;
  int n_done = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  csrx_receiver dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .rd_stb(rd_stb), .ovf_clr(ovf_clr),
    .rx_data(rx_data), .rx_done(rx_done), .rx_err(rx_err),
    .ovf_flag(ovf_flag)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_done) n_done++;
      if (rx_err)  n_err++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
  endtask

  // rd_mode: 0 none, 1 read before deadline edge, 2 read after it
  task automatic send_word(input logic [7:0] d, input int nbits, input int rd_mode);
    for (int i = 0; i < nbits; i++) begin
      sclk_in = 1'b0; sdata_in = d[7-i];
      if (i == 7 && rd_mode == 2) begin
        cyc(6); pulse_rd(); cyc(HALF - 7);
      end else cyc(HALF);
      sclk_in = 1'b1;
      if (i == 6 && rd_mode == 1) begin
        cyc(3); pulse_rd(); cyc(HALF - 4);
      end else cyc(HALF);
    end
  endtask

  task automatic t_reset();
    chk("R1 rx_data", rx_data, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 pulses", {rx_done, rx_err}, 0);
  endtask

  task automatic t_first_word();
    send_word(8'hAA, 8, 0);
    chk("R2 msb-first word", rx_data, 8'hAA);
    chk("R3 one done pulse", n_done, 1);
    chk("R5 no err on first word", n_err, 0);
  endtask

  task automatic t_read_in_time();
    send_word(8'h3C, 8, 1);
    chk("R4 data", rx_data, 8'h3C);
    chk("R4 no err", n_err, 0);
    chk("R4 no overrun", ovf_flag, 0);
  endtask

  task automatic t_late_read();
    send_word(8'h55, 8, 2);
    chk("R7 late read still errs", n_err, 1);
    chk("R5 flag set", ovf_flag, 1);
    chk("R5 data overwritten", rx_data, 8'h55);
  endtask

  task automatic t_repeat_err();
    send_word(8'h0F, 8, 0);
    chk("R6 err repeats", n_err, 2);
    chk("R6 data", rx_data, 8'h0F);
    chk("R3 done count", n_done, 4);
  endtask

  task automatic t_sticky();
    send_word(8'h96, 8, 1);
    chk("R8 no new err", n_err, 2);
    chk("R8 flag sticky after read", ovf_flag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    cyc(1);
    chk("R8 flag cleared", ovf_flag, 0);
  endtask

  task automatic t_disable();
    int d0 = n_done;
    rx_en = 1'b0; cyc(2);
    send_word(8'h00, 8, 0);
    chk("R9 no done while off", n_done, d0);
    chk("R9 data held while off", rx_data, 8'h96);
    rx_en = 1'b1; cyc(2);
    send_word(8'hFF, 3, 0);
    cyc(4);
    rx_en = 1'b0; cyc(4); rx_en = 1'b1; cyc(2);
    pulse_rd(); cyc(2);
    send_word(8'hC3, 8, 0);
    chk("R9 count restarted", rx_data, 8'hC3);
    chk("R9 single done", n_done, d0 + 1);
    chk("R9 no err", n_err, 2);
  endtask

  initial begin
    cyc(4);
    t_reset();
    rst = 1'b0; rx_en = 1'b1;
    cyc(4);
    t_first_word();
    t_read_in_time();
    t_late_read();
    t_repeat_err();
    t_sticky();
    t_disable();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(20000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule